// File: doc/BRIEF.md
# Pulse-Disciplined Timestamp Counter

This block keeps absolute time inside an FPGA. An external once-per-second pulse disciplines it, and it gives other logic a seconds value and a sub-second tick count to timestamp events with. The block does not count seconds locally. The host software writes the seconds value it expects for the coming pulse, and the rising edge of that pulse commits the value. Between pulses, a tick counter driven by the local clock measures the fraction of the second.

The pulse input is asynchronous. It passes through a flop synchronizer and a registered edge detector, and each detected rising edge commits the time exactly once. If the host fails to write a value before a pulse arrives, the block advances the previous second by one and raises a stale indication. If the next pulse fails to arrive, the tick counter stops at its last value and the time is marked as no longer valid. A snapshot request copies seconds and ticks in the same cycle, so a reader never gets a torn timestamp.

Top module: `pps_timebase`

## Requirements
- R1: While `rst` is high and after its release, `sec_out`, `tick_out`, `time_valid`, `trig_seen`, `overrun` and `stale` are all 0.
- R2: A rising edge on `pulse_in` commits time at the fourth rising clock edge, counting the first edge that samples `pulse_in` high. Nothing changes at the third edge. A pulse held high commits only once.
- R3: On a commit after at least one host write since the previous commit, `sec_out` takes the written value, `stale` is 0 and `time_valid` is 1.
- R4: A commit sets `tick_out` to 0. In every other cycle where `tick_out` is below `TICKS_PER_SEC-1`, it increases by exactly one.
- R5: When `tick_out` is at `TICKS_PER_SEC-1` and no commit occurs, it holds that value and `overrun` becomes 1. `time_valid` then goes to 0. The next commit clears `overrun` and sets `time_valid` again.
- R6: On a commit with no host write since the previous commit, `sec_out` becomes its previous value plus one, modulo 2^`SEC_W` (the maximum value is followed by 0), and `stale` is 1.
- R7: `trig_seen` stays 0 until the first commit after reset. From then on it stays 1 until reset, including while an overrun is in effect.
- R8: One cycle after `snap_req` is high, `snap_sec` and `snap_tick` hold the values that `sec_out` and `tick_out` had in the request cycle, and `snap_done` is 1 for that one cycle.
- R9: When the host writes several times between two commits, the last written value is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous once-per-second reference pulse |
| host_wr | input | 1 | Write strobe for the staged seconds value |
| host_sec | input | SEC_W | Seconds value to commit at the next pulse |
| snap_req | input | 1 | Request a consistent timestamp copy |
| sec_out | output | SEC_W | Current whole seconds |
| tick_out | output | TICK_W | Local clock ticks since the last commit |
| time_valid | output | 1 | Time committed and not overrun |
| trig_seen | output | 1 | Sticky: a pulse has been seen since reset |
| overrun | output | 1 | Tick counter saturated before a pulse |
| stale | output | 1 | Last commit was auto-incremented, not host-written |
| snap_sec | output | SEC_W | Snapshot seconds |
| snap_tick | output | TICK_W | Snapshot ticks |
| snap_done | output | 1 | Snapshot registers updated this cycle |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 16 and `SEC_W` set to 8. With 16 ticks per second, the tick counter saturates within a few dozen cycles, so the overrun path and its recovery on the next pulse are exercised directly. With 8-bit seconds, the bench can write the all-ones value and then omit the host write, which shows the stale increment wrapping to zero.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned DEF_TICKS_PER_SEC = 40_000_000;
  localparam int unsigned DEF_SEC_W         = 32;
  localparam int unsigned DEF_SYNC_STAGES   = 2;
endpackage

// File: rtl/tbase_pulse_edge.sv
module tbase_pulse_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      rise  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-1:0], pulse_in};
      rise  <= shreg[STAGES-1] & ~shreg[STAGES];
    end
  end

  // R2: one detected edge yields a single-cycle commit strobe
  p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tbase_subsec_count.sv
module tbase_subsec_count #(
  parameter int unsigned TICKS_PER_SEC = 40_000_000,
  localparam int unsigned TICK_W = $clog2(TICKS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  output logic [TICK_W-1:0] tick,
  output logic              overrun
);
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(TICKS_PER_SEC - 1);

  logic at_max;
  assign at_max = (tick == TICK_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      overrun <= 1'b0;
    end else if (commit) begin
      tick    <= '0;
      overrun <= 1'b0;
    end else if (at_max) begin
      overrun <= 1'b1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  p_zero_on_commit_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> (tick == '0) && !overrun);
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!commit && tick != TICK_MAX) |=> tick == TICK_W'($past(tick) + 1'b1));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (!commit && tick == TICK_MAX) |=> (tick == TICK_MAX) && overrun);
endmodule

// File: rtl/tbase_sec_stage.sv
module tbase_sec_stage #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic             lost,
  input  logic             host_wr,
  input  logic [SEC_W-1:0] host_sec,
  output logic [SEC_W-1:0] sec,
  output logic             valid,
  output logic             seen,
  output logic             stale
);
  logic [SEC_W-1:0] staged;
  logic             fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= '0;
      fresh  <= 1'b0;
      sec    <= '0;
      valid  <= 1'b0;
      seen   <= 1'b0;
      stale  <= 1'b0;
    end else begin
      if (host_wr) staged <= host_sec;
      if (commit) begin
        fresh <= host_wr;
        seen  <= 1'b1;
        valid <= 1'b1;
        if (fresh) begin
          sec   <= staged;
          stale <= 1'b0;
        end else begin
          sec   <= sec + 1'b1;
          stale <= 1'b1;
        end
      end else begin
        if (host_wr) fresh <= 1'b1;
        if (lost) valid <= 1'b0;
      end
    end
  end

  p_take_host_r3: assert property (@(posedge clk) disable iff (rst)
    (commit && fresh) |=> (sec == $past(staged)) && !stale && valid);
  p_stale_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (commit && !fresh) |=> (sec == SEC_W'($past(sec) + 1'b1)) && stale);
  p_lost_r5: assert property (@(posedge clk) disable iff (rst)
    (lost && !commit) |=> !valid);
  p_seen_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    seen |=> seen);
endmodule

// File: rtl/tbase_snapshot.sv
module tbase_snapshot #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [SEC_W-1:0]  sec_in,
  input  logic [TICK_W-1:0] tick_in,
  output logic [SEC_W-1:0]  sec_cap,
  output logic [TICK_W-1:0] tick_cap,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cap  <= '0;
      tick_cap <= '0;
      done     <= 1'b0;
    end else begin
      done <= req;
      if (req) begin
        sec_cap  <= sec_in;
        tick_cap <= tick_in;
      end
    end
  end

  p_snap_pair_r8: assert property (@(posedge clk) disable iff (rst)
    req |=> done && (sec_cap == $past(sec_in)) && (tick_cap == $past(tick_in)));
endmodule

// File: rtl/pps_timebase.sv
module pps_timebase
  import timebase_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = DEF_TICKS_PER_SEC,
  parameter int unsigned SEC_W         = DEF_SEC_W,
  parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
  localparam int unsigned TICK_W       = $clog2(TICKS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_in,
  input  logic              host_wr,
  input  logic [SEC_W-1:0]  host_sec,
  input  logic              snap_req,
  output logic [SEC_W-1:0]  sec_out,
  output logic [TICK_W-1:0] tick_out,
  output logic              time_valid,
  output logic              trig_seen,
  output logic              overrun,
  output logic              stale,
  output logic [SEC_W-1:0]  snap_sec,
  output logic [TICK_W-1:0] snap_tick,
  output logic              snap_done
);
  logic commit;

  tbase_pulse_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .rise(commit)
  );

  tbase_subsec_count #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ticks (
    .clk(clk), .rst(rst), .commit(commit), .tick(tick_out), .overrun(overrun)
  );

  tbase_sec_stage #(.SEC_W(SEC_W)) u_secs (
    .clk(clk), .rst(rst), .commit(commit), .lost(overrun),
    .host_wr(host_wr), .host_sec(host_sec),
    .sec(sec_out), .valid(time_valid), .seen(trig_seen), .stale(stale)
  );

  tbase_snapshot #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_snap (
    .clk(clk), .rst(rst), .req(snap_req), .sec_in(sec_out), .tick_in(tick_out),
    .sec_cap(snap_sec), .tick_cap(snap_tick), .done(snap_done)
  );

  // R1: nothing is reported before the first commit
  p_quiet_until_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (!trig_seen && !commit) |=> !time_valid);
endmodule

// File: tb/test_pps_timebase.sv
`timescale 1ns/1ps
module test_pps_timebase;
  localparam int unsigned TPS = 16;
  localparam int unsigned SW  = 8;
  localparam int unsigned TW  = $clog2(TPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic host_wr = 1'b0;
  logic [SW-1:0] host_sec = '0;
  logic snap_req = 1'b0;
  logic [SW-1:0] sec_out, snap_sec;
  logic [TW-1:0] tick_out, snap_tick;
  logic time_valid, trig_seen, overrun, stale, snap_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pps_timebase #(.TICKS_PER_SEC(TPS), .SEC_W(SW)) i_pps_timebase (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .host_wr(host_wr),
    .host_sec(host_sec), .snap_req(snap_req), .sec_out(sec_out),
    .tick_out(tick_out), .time_valid(time_valid), .trig_seen(trig_seen),
    .overrun(overrun), .stale(stale), .snap_sec(snap_sec),
    .snap_tick(snap_tick), .snap_done(snap_done)
  );

  // {write, double write, value, expected seconds}
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 8'd10,  8'd10},
    {1'b1, 1'b1, 8'd11,  8'd11},
    {1'b0, 1'b0, 8'd0,   8'd12},
    {1'b1, 1'b0, 8'd255, 8'd255},
    {1'b0, 1'b0, 8'd0,   8'd0},
    {1'b1, 1'b1, 8'd42,  8'd42}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [SW-1:0] v);
    @(negedge clk);
    host_wr  = 1'b1;
    host_sec = v;
    @(negedge clk);
    host_wr  = 1'b0;
  endtask

  // raise the pulse, wait for the commit edge, leave at a negedge
  task automatic fire_pulse();
    @(negedge clk);
    pulse_in = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop_pulse();
    pulse_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "sec_out", 32'(sec_out), 0);
    chk("R1", "tick_out", 32'(tick_out), 0);
    chk("R1", "time_valid", 32'(time_valid), 0);
    chk("R1", "trig_seen", 32'(trig_seen), 0);
    chk("R1", "overrun", 32'(overrun), 0);
    chk("R1", "stale", 32'(stale), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "time_valid after release", 32'(time_valid), 0);

    // R2 latency, R7 first commit, R3 host value
    host_write(8'd7);
    @(negedge clk);
    pulse_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2", "no commit at third edge", 32'(trig_seen), 0);
    chk("R7", "seen before first pulse", 32'(trig_seen), 0);
    @(negedge clk);
    chk("R2", "seen at fourth edge", 32'(trig_seen), 1);
    chk("R3", "sec_out", 32'(sec_out), 7);
    chk("R3", "time_valid", 32'(time_valid), 1);
    chk("R3", "stale", 32'(stale), 0);
    chk("R4", "tick reset", 32'(tick_out), 0);
    repeat (5) @(negedge clk);
    chk("R2", "held pulse commits once", 32'(tick_out), 5);
    chk("R4", "tick counts", 32'(tick_out), 5);
    drop_pulse();

    // table walk: R3, R6, R9
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][17]) begin
        if (VEC[i][16]) host_write(~VEC[i][15:8]);
        host_write(VEC[i][15:8]);
      end
      fire_pulse();
      if (VEC[i][17]) begin
        chk(VEC[i][16] ? "R9" : "R3", "sec_out", 32'(sec_out), 32'(VEC[i][7:0]));
        chk("R3", "stale", 32'(stale), 0);
      end else begin
        chk("R6", "sec_out", 32'(sec_out), 32'(VEC[i][7:0]));
        chk("R6", "stale", 32'(stale), 1);
      end
      chk("R4", "tick reset", 32'(tick_out), 0);
      chk("R3", "time_valid", 32'(time_valid), 1);
      drop_pulse();
    end

    // R5: saturation and recovery
    repeat (24) @(negedge clk);
    chk("R5", "tick held", 32'(tick_out), TPS - 1);
    chk("R5", "overrun", 32'(overrun), 1);
    chk("R5", "time_valid lost", 32'(time_valid), 0);
    chk("R7", "seen during overrun", 32'(trig_seen), 1);
    host_write(8'd50);
    fire_pulse();
    chk("R5", "overrun cleared", 32'(overrun), 0);
    chk("R5", "time_valid back", 32'(time_valid), 1);
    chk("R4", "tick reset", 32'(tick_out), 0);
    chk("R3", "sec_out", 32'(sec_out), 50);
    drop_pulse();

    // R8: snapshot
    begin
      logic [SW-1:0] s_exp;
      logic [TW-1:0] t_exp;
      @(negedge clk);
      s_exp = sec_out;
      t_exp = tick_out;
      snap_req = 1'b1;
      @(negedge clk);
      snap_req = 1'b0;
      chk("R8", "snap_tick", 32'(snap_tick), 32'(t_exp));
      chk("R8", "snap_sec", 32'(snap_sec), 32'(s_exp));
      chk("R8", "snap_done", 32'(snap_done), 1);
      @(negedge clk);
      chk("R8", "snap_done single", 32'(snap_done), 0);
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "sec_out", 32'(sec_out), 0);
    chk("R1", "trig_seen", 32'(trig_seen), 0);
    chk("R1", "time_valid", 32'(time_valid), 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule